// File: doc/BRIEF.md
# Eight-Bit Event Counter with Shared Prescaler

This block is an 8-bit free-running counter with an overflow flag that software clears. The counter advances on one of two event sources. The first is a one-cycle strobe from the core's instruction clock. The second is an edge on an external pin, and software picks whether a rising or a falling edge counts. The pin is asynchronous, so it passes through a synchroniser before edge detection.

A single 8-bit ripple prescaler serves one of two clients, chosen by an assignment bit. Given to the counter, it divides the selected event stream by 2 to 256 before the counter sees it. Given to the watchdog, it divides the watchdog oscillator strobe by 1 to 128 and drives the watchdog tick output, and the counter then counts every event. Whichever client does not own the prescaler runs undivided. The watchdog reset logic itself lives elsewhere.

Top module: `shared_pre_timer`

## Requirements
- R1: With `cfg_pre_wdog`=0, rate code k (0..7 on `cfg_rate`) makes the counter advance once per 2^(k+1) selected events.
- R2: With `cfg_pre_wdog`=1, rate code k makes `wdog_tick` pulse once per 2^k `wdt_src` strobes, and the counter advances on every selected event.
- R3: With `cfg_pre_wdog`=0, `wdog_tick` equals `wdt_src` in every cycle, so no watchdog strobe is divided or lost.
- R4: With `cfg_src_ext`=0 the counter counts `icyc_en` strobes. With `cfg_src_ext`=1 it counts pin edges, and `icyc_en` has no effect on `cnt_q`.
- R5: With `cfg_fall_edge`=0 only a 0-to-1 transition of `ext_pin` counts. With `cfg_fall_edge`=1 only a 1-to-0 transition counts.
- R6: `ext_pin` is synchronised by two flops. With no division, a pin transition driven between clock edges changes `cnt_q` at the third rising clock edge after it, and not at the second.
- R7: An increment at 0xFF wraps `cnt_q` to 0x00, and that same clock edge sets `ovf_flag`.
- R8: `ovf_flag` is never cleared by hardware. A write (`flag_wr`=1) loads `flag_wdata`. A wrap in the same cycle as a clearing write leaves the flag set.
- R9: `cnt_wr`=1 loads `cnt_wdata` on the next edge, ahead of any increment in that cycle. It also clears the prescaler count, so the next increment is a full prescale period away.
- R10: Synchronous reset clears `cnt_q`, `ovf_flag` and the prescaler count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icyc_en | input | 1 | Instruction-clock strobe, one cycle per instruction |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_src | input | 1 | Watchdog oscillator strobe |
| cfg_src_ext | input | 1 | 0: count `icyc_en`, 1: count pin edges |
| cfg_fall_edge | input | 1 | 0: rising pin edge, 1: falling pin edge |
| cfg_pre_wdog | input | 1 | 0: prescaler on counter, 1: prescaler on watchdog |
| cfg_rate | input | 3 | Prescaler rate code |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| flag_wr | input | 1 | Overflow flag write strobe |
| flag_wdata | input | 1 | Overflow flag write value |
| cnt_q | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdog_tick | output | 1 | Watchdog tick, prescaled or passed through |

## Verification
The bench sweeps all eight rate codes under both prescaler assignments. A design that swapped the two ratio tables, or kept dividing the counter after the prescaler moved to the watchdog, would end each run off by a factor of two or more. It times a pin transition against the clock. A missing synchroniser stage shows up as an early count, and reversed polarity as a count on the wrong half of a pulse. It loads the counter partway through a prescale period: a design that keeps the old prescaler count advances one strobe too early. It also lines up a wrap with a clearing write, so a design that lets software win loses the overflow.

// File: rtl/spt_pkg.sv
package spt_pkg;

    localparam int RATE_W = 3;

    typedef struct packed {
        logic              src_ext;
        logic              fall_edge;
        logic              pre_wdog;
        logic [RATE_W-1:0] rate;
    } spt_cfg_t;

    typedef struct packed {
        logic tmr_event;
        logic pre_in;
        logic pre_out;
        logic tmr_inc;
        logic wd_tick;
    } spt_route_t;

    // log2 of the division ratio: the counter table starts at 2, the watchdog table at 1
    function automatic int unsigned div_shift(logic to_wdog, logic [RATE_W-1:0] rate);
        return to_wdog ? int'(rate) : int'(rate) + 1;
    endfunction

endpackage

// File: rtl/spt_edge_sync.sv
module spt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], pin};
    end

    always_comb begin
        rise = chain[STAGES-1] & ~chain[STAGES];
        fall = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/spt_prescaler.sv
module spt_prescaler
    import spt_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              ev_in,
    input  logic              to_wdog,
    input  logic [RATE_W-1:0] rate,
    output logic              ev_out
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] mask;
    int unsigned      sh;

    always_comb begin
        sh = div_shift(to_wdog, rate);
        for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(sh));
    end

    assign ev_out = ev_in && ((pre_cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr)  pre_cnt <= '0;
        else if (ev_out) pre_cnt <= '0;
        else if (ev_in)  pre_cnt <= pre_cnt + PRE_W'(1);
    end
endmodule

// File: rtl/spt_count_core.sv
module spt_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    logic wrap;
    assign wrap = inc && !wr && (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            if (wr)       cnt <= wdata;
            else if (inc) cnt <= cnt + CNT_W'(1);
            if (wrap)         flag <= 1'b1;
            else if (flag_wr) flag <= flag_wdata;
        end
    end
endmodule

// File: rtl/shared_pre_timer.sv
module shared_pre_timer
    import spt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              icyc_en,
    input  logic              ext_pin,
    input  logic              wdt_src,
    input  logic              cfg_src_ext,
    input  logic              cfg_fall_edge,
    input  logic              cfg_pre_wdog,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              ovf_flag,
    output logic              wdog_tick
);
    spt_cfg_t   cfg;
    spt_route_t rt;
    logic       pin_rise, pin_fall;

    assign cfg = '{src_ext: cfg_src_ext, fall_edge: cfg_fall_edge,
                   pre_wdog: cfg_pre_wdog, rate: cfg_rate};

    spt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .pin (ext_pin),
        .rise(pin_rise),
        .fall(pin_fall)
    );

    always_comb begin
        rt.pre_out   = 1'b0;
        rt.tmr_event = cfg.src_ext ? (cfg.fall_edge ? pin_fall : pin_rise) : icyc_en;
        rt.pre_in    = cfg.pre_wdog ? wdt_src : rt.tmr_event;
        rt.tmr_inc   = 1'b0;
        rt.wd_tick   = 1'b0;
    end

    logic pre_out_w;

    spt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (cnt_wr),
        .ev_in  (rt.pre_in),
        .to_wdog(cfg.pre_wdog),
        .rate   (cfg.rate),
        .ev_out (pre_out_w)
    );

    logic tmr_inc;
    assign tmr_inc   = cfg.pre_wdog ? rt.tmr_event : pre_out_w;
    assign wdog_tick = cfg.pre_wdog ? pre_out_w : wdt_src;

    spt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .inc       (tmr_inc),
        .wr        (cnt_wr),
        .wdata     (cnt_wdata),
        .flag_wr   (flag_wr),
        .flag_wdata(flag_wdata),
        .cnt       (cnt_q),
        .flag      (ovf_flag)
    );
endmodule

// File: rtl/shared_pre_timer_chk.sv
module shared_pre_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wdt_src,
    input logic             cfg_pre_wdog,
    input logic [2:0]       cfg_rate,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             flag_wr,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_flag,
    input logic             wdog_tick,
    input logic             tmr_inc,
    input logic             pre_out
);
    // R1: counter-side ratios are at least two, so prescaler output never repeats back to back
    assert_no_double_R1: assert property (@(posedge clk) disable iff (rst)
        !cfg_pre_wdog && pre_out && !cnt_wr |=> !(pre_out && !cfg_pre_wdog));

    // R2: watchdog side at rate code 0 divides by one
    assert_wd_div1_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_pre_wdog && cfg_rate == 3'd0 |-> wdog_tick == wdt_src);

    // R7: wrap goes to zero and raises the flag
    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        tmr_inc && !cnt_wr && cnt_q == {CNT_W{1'b1}} |=> cnt_q == '0 && ovf_flag);

    // R8: flag only falls through a software write
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_flag && !flag_wr |=> ovf_flag);

    // R9: write loads the value regardless of increment
    assert_load_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> cnt_q == $past(cnt_wdata));

    // R9: without write or increment the count holds
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr && !tmr_inc |=> $stable(cnt_q));
endmodule

bind shared_pre_timer shared_pre_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wdt_src     (wdt_src),
    .cfg_pre_wdog(cfg_pre_wdog),
    .cfg_rate    (cfg_rate),
    .cnt_wr      (cnt_wr),
    .cnt_wdata   (cnt_wdata),
    .flag_wr     (flag_wr),
    .cnt_q       (cnt_q),
    .ovf_flag    (ovf_flag),
    .wdog_tick   (wdog_tick),
    .tmr_inc     (tmr_inc),
    .pre_out     (pre_out_w)
);

// File: tb/tb_shared_pre_timer.sv
module tb_shared_pre_timer;
    logic       clk = 1'b0;
    logic       rst;
    logic       icyc_en, ext_pin, wdt_src;
    logic       cfg_src_ext, cfg_fall_edge, cfg_pre_wdog;
    logic [2:0] cfg_rate;
    logic       cnt_wr, flag_wr, flag_wdata;
    logic [7:0] cnt_wdata;
    logic [7:0] cnt_q;
    logic       ovf_flag, wdog_tick;

    int checks = 0;
    int fails  = 0;
    int wd_seen;
    bit done = 0;

    always #10 clk = ~clk;

    shared_pre_timer dut (
        .clk(clk), .rst(rst), .icyc_en(icyc_en), .ext_pin(ext_pin), .wdt_src(wdt_src),
        .cfg_src_ext(cfg_src_ext), .cfg_fall_edge(cfg_fall_edge),
        .cfg_pre_wdog(cfg_pre_wdog), .cfg_rate(cfg_rate),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .cnt_q(cnt_q), .ovf_flag(ovf_flag), .wdog_tick(wdog_tick)
    );

    typedef struct packed {
        logic       wd;
        logic [2:0] rate;
        int         n;
        logic [7:0] exp_cnt;
        int         exp_wd;
    } vec_t;

    // R1 rows (wd=0) and R2 rows (wd=1); R3 via exp_wd on the wd=0 rows
    localparam vec_t VEC [11] = '{
        '{1'b0, 3'd0,  10, 8'd5,  10},
        '{1'b0, 3'd1,  10, 8'd2,  10},
        '{1'b0, 3'd2,  20, 8'd2,  20},
        '{1'b0, 3'd3,  40, 8'd2,  40},
        '{1'b0, 3'd4,  64, 8'd2,  64},
        '{1'b0, 3'd5, 130, 8'd2, 130},
        '{1'b0, 3'd6, 300, 8'd2, 300},
        '{1'b0, 3'd7, 600, 8'd2, 600},
        '{1'b1, 3'd0,  10, 8'd10, 10},
        '{1'b1, 3'd3,  20, 8'd20,  2},
        '{1'b1, 3'd7, 300, 8'd44,  2}
    };

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cnt(logic [7:0] v, logic clr_flag);
        @(negedge clk);
        cnt_wr = 1'b1; cnt_wdata = v;
        flag_wr = clr_flag; flag_wdata = 1'b0;
        @(negedge clk);
        cnt_wr = 1'b0; flag_wr = 1'b0;
    endtask

    task automatic run_pulses(int n);
        wd_seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            icyc_en = 1'b1; wdt_src = 1'b1;
            #1;
            if (wdog_tick) wd_seen++;
        end
        @(negedge clk);
        icyc_en = 1'b0; wdt_src = 1'b0;
    endtask

    task automatic wait_neg(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; icyc_en = 0; ext_pin = 0; wdt_src = 0;
        cfg_src_ext = 0; cfg_fall_edge = 0; cfg_pre_wdog = 0; cfg_rate = 0;
        cnt_wr = 0; cnt_wdata = 0; flag_wr = 0; flag_wdata = 0;
        wait_neg(3);
        rst = 1'b0;
        @(negedge clk);
        check("R10 cnt after reset", cnt_q, 0);
        check("R10 flag after reset", ovf_flag, 0);

        // Prescaler sweep
        for (int v = 0; v < 11; v++) begin
            cfg_pre_wdog = VEC[v].wd; cfg_rate = VEC[v].rate; cfg_src_ext = 1'b0;
            write_cnt(8'h00, 1'b1);
            run_pulses(VEC[v].n);
            check(VEC[v].wd ? "R2 count" : "R1 count", cnt_q, VEC[v].exp_cnt);
            check(VEC[v].wd ? "R2 wdog ticks" : "R3 wdog ticks", wd_seen, VEC[v].exp_wd);
        end

        // R7 wrap and flag
        cfg_pre_wdog = 1'b1; cfg_rate = 3'd0; cfg_src_ext = 1'b0;
        write_cnt(8'hFE, 1'b1);
        run_pulses(1);
        check("R7 cnt at FF", cnt_q, 8'hFF);
        check("R7 flag before wrap", ovf_flag, 0);
        run_pulses(1);
        check("R7 cnt wrapped", cnt_q, 0);
        check("R7 flag on wrap", ovf_flag, 1);

        // R8 sticky, software clear, set beats clear
        run_pulses(5);
        check("R8 flag sticky", ovf_flag, 1);
        @(negedge clk); flag_wr = 1; flag_wdata = 0;
        @(negedge clk); flag_wr = 0;
        check("R8 flag cleared by write", ovf_flag, 0);
        write_cnt(8'hFF, 1'b0);
        @(negedge clk); icyc_en = 1; flag_wr = 1; flag_wdata = 0;
        @(negedge clk); icyc_en = 0; flag_wr = 0;
        check("R8 wrap beats clear", ovf_flag, 1);

        // R9 write priority and prescaler clear
        @(negedge clk); icyc_en = 1; cnt_wr = 1; cnt_wdata = 8'h5A;
        @(negedge clk); icyc_en = 0; cnt_wr = 0;
        check("R9 write beats increment", cnt_q, 8'h5A);
        cfg_pre_wdog = 1'b0; cfg_rate = 3'd1;
        write_cnt(8'h00, 1'b1);
        run_pulses(3);
        check("R9 partial period", cnt_q, 0);
        write_cnt(8'h10, 1'b0);
        run_pulses(3);
        check("R9 prescaler cleared by write", cnt_q, 8'h10);
        run_pulses(1);
        check("R9 full period after write", cnt_q, 8'h11);

        // R5 / R6 external pin
        cfg_pre_wdog = 1'b1; cfg_rate = 3'd0; cfg_src_ext = 1'b1; cfg_fall_edge = 1'b1;
        write_cnt(8'h00, 1'b1);
        ext_pin = 1'b1;
        wait_neg(4);
        check("R5 falling mode ignores rise", cnt_q, 0);
        ext_pin = 1'b0;
        wait_neg(2);
        check("R6 no count after two edges", cnt_q, 0);
        wait_neg(1);
        check("R6 count at third edge", cnt_q, 1);
        cfg_fall_edge = 1'b0;
        @(negedge clk); ext_pin = 1'b1;
        wait_neg(4);
        check("R5 rising mode counts rise", cnt_q, 2);
        ext_pin = 1'b0;
        wait_neg(4);
        check("R5 rising mode ignores fall", cnt_q, 2);

        // R4 internal strobe ignored when pin selected
        run_pulses(5);
        check("R4 icyc ignored in ext mode", cnt_q, 2);
        cfg_src_ext = 1'b0;
        run_pulses(5);
        check("R4 icyc counted in int mode", cnt_q, 7);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule